// File: doc/BRIEF.md
# Bit-Serial Processing Element with Programmable Minterm ALU

This block is one processing element (PE) of a large SIMD array. It holds a single-bit-wide data store with 4096 locations, a bank of 16 one-bit flags, and an ALU with three one-bit inputs and two one-bit outputs. A broadcast controller issues one instruction at a time. Each instruction names an A location, a B location, a flag to read, a flag to write and a 16-bit truth-table code.

The store has one read port. The PE therefore reads and buffers the A bit first, then reads the B bit. It evaluates both outputs on (A, B, selected flag). In a final cycle it writes one result back to the A location and the other into the chosen flag.

The ALU forms all eight minterms of its three inputs. Each output ORs together the minterms that its own 8-bit half of the truth-table code enables, so any two three-input functions can be programmed. The two ALU results are also driven on output ports while the PE signals completion, which is how the controller (or a bench) can observe stored state.

Top module: `bitserial_pe`

## Requirements
- R1: After reset, `busy` and `done` are low and all 16 flags read as 0.
- R2: The memory result equals bit k of `tt_mem`, where k = {A, B, F}: A is bit 2, B is bit 1, F is bit 0. A set bit k includes minterm k.
- R3: The flag result equals bit k of `tt_flag`, with the same minterm index k as in R2.
- R4: The memory result is written to the A location, and a later instruction reads that value.
- R5: The flag result is written only into the flag chosen by `flag_wr_sel`. The other 15 flags keep their values.
- R6: An accepted instruction keeps `busy` high for exactly three cycles. `done` is high only in the third of those cycles, and `res_mem`/`res_flag` hold the results while `done` is high.
- R7: `issue_valid` is accepted only while `busy` is low. An instruction offered while busy has no effect.
- R8: When `addr_a` equals `addr_b`, the B operand equals the A operand's value before the instruction. The A-location write happens after both reads.
- R9: When `flag_rd_sel` equals `flag_wr_sel`, the ALU sees the old flag value, and the new value is stored afterwards.
- R10: Location 0, location 4095 and flag 15 are all addressable and keep their data independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Instruction offered; taken only when idle |
| addr_a | input | 12 | A operand location; also the write-back location |
| addr_b | input | 12 | B operand location |
| flag_rd_sel | input | 4 | Flag used as third ALU input |
| flag_wr_sel | input | 4 | Flag that receives the flag result |
| tt_mem | input | 8 | Minterm enables for the memory result |
| tt_flag | input | 8 | Minterm enables for the flag result |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Write-back cycle; results valid |
| res_mem | output | 1 | Memory result of the current instruction |
| res_flag | output | 1 | Flag result of the current instruction |

## Verification
The bench runs each truth-table vector with a different minterm index. A design that reversed the {A, B, F} bit order, or swapped the two halves of the code, would write the wrong bit into the store or the flag, and the read-back would show it. Three directed tests follow. Same-address operands catch a design that lets B see a value already written. Equal read and write flag selects catch a design that feeds the new flag value back into the ALU. An instruction offered while busy catches a design that accepts it, because that instruction would change a location which must stay at 0. A further test at locations 0 and 4095 and at flag 15 catches address truncation or aliasing.

// File: rtl/spe_pkg.sv
// Shared definitions for the bit-serial PE.
// Assumes a three-phase instruction: read A, read B plus compute, write back.
package spe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RDA  = 2'd1,
        ST_RDB  = 2'd2,
        ST_WB   = 2'd3
    } spe_state_t;

    localparam int ALU_IN = 3;
    localparam int NMINT  = 1 << ALU_IN;
endpackage

// File: rtl/spe_bitmem.sv
// Single-bit-wide store with one combinational read port and one write port.
// Assumes the sequencer never reads and writes in the same cycle; contents are not reset.
module spe_bitmem #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] raddr,
    output logic          rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata
);
    logic store [DEPTH];

    // Read path: current content at the read address.
    assign rdata = store[raddr];

    // Write path: commit one bit when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/spe_flags.sv
// Bank of one-bit flags with one read select and one write select.
// Assumes at most one flag is written per cycle; all flags clear on reset.
module spe_flags #(
    parameter int NFLAG = 16,
    localparam int FSW = $clog2(NFLAG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [FSW-1:0] rd_sel,
    output logic           rd_bit,
    input  logic           we,
    input  logic [FSW-1:0] wr_sel,
    input  logic           wr_bit
);
    logic [NFLAG-1:0] flag_q;

    // Read mux: selected flag to the ALU.
    assign rd_bit = flag_q[rd_sel];

    // Flag storage: reset to zero, update one selected bit on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (we) begin
            flag_q[wr_sel] <= wr_bit;
        end
    end

    // R5: a write changes at most the one selected flag.
    assert_one_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ($countones(flag_q ^ $past(flag_q)) <= 1));

    // R5: without a write, no flag moves.
    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flag_q));
endmodule

// File: rtl/spe_minterm_alu.sv
// Two-output ALU over three one-bit inputs in sum-of-products form.
// Index of a minterm is {a, b, f} with a as the most significant bit.
module spe_minterm_alu
    import spe_pkg::*;
(
    input  logic             a,
    input  logic             b,
    input  logic             f,
    input  logic [NMINT-1:0] tt_mem,
    input  logic [NMINT-1:0] tt_flag,
    output logic             y_mem,
    output logic             y_flag
);
    logic [ALU_IN-1:0] idx;
    logic [NMINT-1:0]  mt;

    // Minterm index formed from the three operand bits.
    assign idx = {a, b, f};

    // One decoder output per minterm.
    for (genvar k = 0; k < NMINT; k++) begin : g_mt
        assign mt[k] = (idx == ALU_IN'(k));
    end

    // Each output ORs the minterms its code enables.
    assign y_mem  = |(mt & tt_mem);
    assign y_flag = |(mt & tt_flag);
endmodule

// File: rtl/spe_seq.sv
// Instruction sequencer: accepts an instruction when idle, latches it,
// then steps through read A, read B plus compute, and write back.
module spe_seq
    import spe_pkg::*;
#(
    parameter int AW  = 12,
    parameter int FSW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [FSW-1:0]   flag_rd_sel,
    input  logic [FSW-1:0]   flag_wr_sel,
    input  logic [NMINT-1:0] tt_mem,
    input  logic [NMINT-1:0] tt_flag,
    output logic             busy,
    output logic             done,
    output logic             ld_a,
    output logic             ld_res,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    lat_a,
    output logic [FSW-1:0]   lat_rd,
    output logic [FSW-1:0]   lat_wr,
    output logic [NMINT-1:0] lat_ttm,
    output logic [NMINT-1:0] lat_ttf
);
    spe_state_t    state_q;
    logic [AW-1:0] lat_b;

    // State register and instruction latch; capture only from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_a   <= '0;
            lat_b   <= '0;
            lat_rd  <= '0;
            lat_wr  <= '0;
            lat_ttm <= '0;
            lat_ttf <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (issue_valid) begin
                    state_q <= ST_RDA;
                    lat_a   <= addr_a;
                    lat_b   <= addr_b;
                    lat_rd  <= flag_rd_sel;
                    lat_wr  <= flag_wr_sel;
                    lat_ttm <= tt_mem;
                    lat_ttf <= tt_flag;
                end
                ST_RDA:  state_q <= ST_RDB;
                ST_RDB:  state_q <= ST_WB;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Phase strobes and read-address mux for the single read port.
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_WB);
    assign ld_a    = (state_q == ST_RDA);
    assign ld_res  = (state_q == ST_RDB);
    assign rd_addr = (state_q == ST_RDB) ? lat_b : lat_a;

    // R6: an accepted instruction raises busy on the next cycle.
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && issue_valid) |=> busy);

    // R6: done is preceded by two busy cycles and followed by idle.
    assert_done_third_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy, 1) && $past(busy, 2) && !$past(done, 1)));
    assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7: offers made while busy leave the latched instruction untouched.
    assert_busy_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_ttm)));
endmodule

// File: rtl/bitserial_pe.sv
// One bit-serial SIMD processing element: single-port bit store, flag bank
// and minterm ALU. The A bit is buffered while B is fetched; both results
// commit together in the write-back cycle.
module bitserial_pe
    import spe_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int NFLAG = 16,
    localparam int AW  = $clog2(DEPTH),
    localparam int FSW = $clog2(NFLAG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [AW-1:0]    addr_a,
    input  logic [AW-1:0]    addr_b,
    input  logic [FSW-1:0]   flag_rd_sel,
    input  logic [FSW-1:0]   flag_wr_sel,
    input  logic [NMINT-1:0] tt_mem,
    input  logic [NMINT-1:0] tt_flag,
    output logic             busy,
    output logic             done,
    output logic             res_mem,
    output logic             res_flag
);
    logic             ld_a, ld_res;
    logic [AW-1:0]    rd_addr, lat_a;
    logic [FSW-1:0]   lat_rd, lat_wr;
    logic [NMINT-1:0] lat_ttm, lat_ttf;
    logic             mem_rd, flag_rd;
    logic             a_buf;
    logic             y_mem, y_flag;
    logic             res_mem_q, res_flag_q;

    spe_seq #(.AW(AW), .FSW(FSW)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .addr_a(addr_a), .addr_b(addr_b),
        .flag_rd_sel(flag_rd_sel), .flag_wr_sel(flag_wr_sel),
        .tt_mem(tt_mem), .tt_flag(tt_flag),
        .busy(busy), .done(done), .ld_a(ld_a), .ld_res(ld_res),
        .rd_addr(rd_addr), .lat_a(lat_a), .lat_rd(lat_rd), .lat_wr(lat_wr),
        .lat_ttm(lat_ttm), .lat_ttf(lat_ttf)
    );

    spe_bitmem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .raddr(rd_addr), .rdata(mem_rd),
        .we(done), .waddr(lat_a), .wdata(res_mem_q)
    );

    spe_flags #(.NFLAG(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .rd_sel(lat_rd), .rd_bit(flag_rd),
        .we(done), .wr_sel(lat_wr), .wr_bit(res_flag_q)
    );

    spe_minterm_alu u_alu (
        .a(a_buf), .b(mem_rd), .f(flag_rd),
        .tt_mem(lat_ttm), .tt_flag(lat_ttf),
        .y_mem(y_mem), .y_flag(y_flag)
    );

    // Operand buffer for A: single read port forces A to be held while B is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_buf <= 1'b0;
        end else if (ld_a) begin
            a_buf <= mem_rd;
        end
    end

    // Result registers: capture both ALU outputs at the end of the B-read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_mem_q  <= 1'b0;
            res_flag_q <= 1'b0;
        end else if (ld_res) begin
            res_mem_q  <= y_mem;
            res_flag_q <= y_flag;
        end
    end

    assign res_mem  = res_mem_q;
    assign res_flag = res_flag_q;

    // R6: results do not change while the write-back is in progress.
    assert_res_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(res_mem) && $stable(res_flag)));

    // R8: the A operand buffer is frozen from the B read through write-back.
    assert_abuf_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_res |=> $stable(a_buf));
endmodule

// File: tb/bitserial_pe_tb.sv
`timescale 1ns/1ps
module bitserial_pe_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [11:0] addr_a = '0, addr_b = '0;
    logic [3:0] flag_rd_sel = '0, flag_wr_sel = '0;
    logic [7:0] tt_mem = '0, tt_flag = '0;
    logic       busy, done, res_mem, res_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic r_mem, r_flag;

    always #5 clk = ~clk;

    bitserial_pe u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .addr_a(addr_a), .addr_b(addr_b),
        .flag_rd_sel(flag_rd_sel), .flag_wr_sel(flag_wr_sel),
        .tt_mem(tt_mem), .tt_flag(tt_flag),
        .busy(busy), .done(done), .res_mem(res_mem), .res_flag(res_flag)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one instruction, wait for write-back, return to idle.
    task automatic exec(input logic [11:0] aa, input logic [11:0] bb,
                        input logic [3:0] fr, input logic [3:0] fw,
                        input logic [7:0] ttm, input logic [7:0] ttf);
        @(negedge clk);
        addr_a = aa; addr_b = bb; flag_rd_sel = fr; flag_wr_sel = fw;
        tt_mem = ttm; tt_flag = ttf; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        while (!done) @(negedge clk);
        r_mem = res_mem; r_flag = res_flag;
        @(negedge clk);
    endtask

    // Helpers built only from instructions; flag 0 / location 0 pass through.
    task automatic set_bit(input logic [11:0] ad, input logic v);
        exec(ad, ad, 4'd0, 4'd0, v ? 8'hFF : 8'h00, 8'hAA);
    endtask
    task automatic set_flag(input logic [3:0] j, input logic v);
        exec(12'd0, 12'd0, j, j, 8'hF0, v ? 8'hFF : 8'h00);
    endtask
    task automatic read_bit(input logic [11:0] ad, output logic v);
        exec(ad, ad, 4'd0, 4'd0, 8'hF0, 8'hAA);
        v = r_mem;
    endtask
    task automatic read_flag(input logic [3:0] j, output logic v);
        exec(12'd0, 12'd0, j, j, 8'hF0, 8'hAA);
        v = r_flag;
    endtask

    // Vector fields: {A, B, F, tt_mem, tt_flag, exp_mem, exp_flag}
    localparam logic [20:0] VEC [8] = '{
        {1'b1, 1'b1, 1'b0, 8'hC0, 8'h96, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b1, 8'hC0, 8'hE8, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 8'h96, 8'hE8, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 8'h01, 8'hFE, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'h7F, 8'h80, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b0, 8'h04, 8'hFB, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'h10, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b1, 8'h02, 8'hFF, 1'b1, 1'b1}
    };

    initial begin
        logic v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        read_flag(4'd15, v); chk("R1 flag15", v, 0);
        read_flag(4'd3, v);  chk("R1 flag3", v, 0);

        // R2/R3/R4/R5: truth-table vectors
        set_flag(4'd9, 1'b1);
        for (int i = 0; i < 8; i++) begin
            set_bit(12'd10, VEC[i][20]);
            set_bit(12'd20, VEC[i][19]);
            set_flag(4'd3, VEC[i][18]);
            set_flag(4'd5, ~VEC[i][0]);
            exec(12'd10, 12'd20, 4'd3, 4'd5, VEC[i][17:10], VEC[i][9:2]);
            chk("R2 res_mem", r_mem, VEC[i][1]);
            chk("R3 res_flag", r_flag, VEC[i][0]);
            read_bit(12'd10, v);  chk("R4 stored A", v, VEC[i][1]);
            read_flag(4'd5, v);   chk("R5 target flag", v, VEC[i][0]);
            read_flag(4'd9, v);   chk("R5 other flag", v, 1);
            read_flag(4'd3, v);   chk("R5 read flag", v, VEC[i][18]);
        end

        // R6 and R7: timing and ignored offer while busy
        set_bit(12'd30, 1'b0);
        set_bit(12'd40, 1'b1);
        @(negedge clk);
        addr_a = 12'd40; addr_b = 12'd40; flag_rd_sel = 4'd0; flag_wr_sel = 4'd0;
        tt_mem = 8'hF0; tt_flag = 8'hAA; issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
        chk("R6 cycle1 busy", busy, 1); chk("R6 cycle1 done", done, 0);
        @(negedge clk);
        chk("R6 cycle2 busy", busy, 1); chk("R6 cycle2 done", done, 0);
        addr_a = 12'd30; addr_b = 12'd30; tt_mem = 8'hFF; issue_valid = 1'b1;
        @(negedge clk);
        chk("R6 cycle3 busy", busy, 1); chk("R6 cycle3 done", done, 1);
        chk("R6 res_mem", res_mem, 1);
        issue_valid = 1'b0;
        @(negedge clk);
        chk("R7 idle after", busy, 0);
        read_bit(12'd30, v); chk("R7 ignored write", v, 0);

        // R8: same A and B address
        set_bit(12'd50, 1'b1);
        exec(12'd50, 12'd50, 4'd0, 4'd0, 8'hC0, 8'hAA);
        chk("R8 B sees A", r_mem, 1);
        exec(12'd50, 12'd50, 4'd0, 4'd0, 8'h0F, 8'hAA);
        chk("R8 not-A result", r_mem, 0);
        read_bit(12'd50, v); chk("R8 write after reads", v, 0);

        // R9: same read and write flag
        set_flag(4'd7, 1'b1);
        set_flag(4'd6, 1'b1);
        exec(12'd0, 12'd0, 4'd7, 4'd7, 8'hF0, 8'h55);
        chk("R9 old flag used", r_flag, 0);
        read_flag(4'd7, v); chk("R9 flag7 stored", v, 0);
        read_flag(4'd6, v); chk("R9 flag6 kept", v, 1);

        // R10: extreme addresses and last flag
        set_bit(12'd4095, 1'b1);
        set_bit(12'd0, 1'b0);
        read_bit(12'd4095, v); chk("R10 loc4095", v, 1);
        read_bit(12'd0, v);    chk("R10 loc0", v, 0);
        set_flag(4'd15, 1'b1);
        read_flag(4'd15, v);   chk("R10 flag15", v, 1);
        read_flag(4'd14, v);   chk("R10 flag14", v, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule